// File: doc/BRIEF.md
# Variable-Length Instruction Format Decoder

This block looks at the leading byte of a byte-oriented instruction that is three to six bytes long and works out what the instruction looks like. It sorts the instruction into one of three classes: a command with no operands, a one-operand instruction, or a two-operand instruction. It then reports the total byte length. For each operand it also forms an effective address. That address is either a full 16-bit direct address or the sum of a 16-bit index register and an unsigned 8-bit displacement.

All six instruction bytes and both index registers are presented together with a strobe. One clock later the decoded class, the operation number, the qualifier byte, the length and the two addresses appear with a valid flag. They stay unchanged until the next strobe. Fetching, executing and memory access belong to neighbouring logic.

The upper four opcode bits carry one two-bit addressing-mode field per operand. That single field fixes the class, the length and the form of every operand address.

Top module: `instr_format_decoder`

## Requirements
- R1: While reset is asserted, and before the first strobe after it, `dec_vld` is 0 and every other output is 0.
- R2: `dec_vld` is 1 in exactly the cycle after a cycle with `ins_stb` high. When `ins_stb` is low, the class, op, qualifier, length and addresses keep their previous values.
- R3: An upper opcode nibble of 1111 gives class 00 (command), length 3, and both addresses 0.
- R4: An upper nibble of the form 11xx or xx11, other than 1111, gives class 01 (one operand). The other bit pair (xx) is the mode of operand 1.
- R5: Every other upper nibble gives class 10 (two operands). Bits 7:6 of the opcode give the mode of operand 1 and bits 5:4 give the mode of operand 2.
- R6: The length is 2, plus 2 for each direct operand, plus 1 for each based operand. The result is always between 3 and 6.
- R7: Mode 00 (direct) takes a 16-bit address from two consecutive address-field bytes, high byte first.
- R8: Mode 01 adds the displacement byte to index register 1, and mode 10 adds it to index register 2. The displacement is unsigned and the sum wraps modulo 65536.
- R9: The field of operand 1 starts at byte 2. The field of operand 2 starts right after it, at byte 4 when operand 1 is direct and at byte 3 when operand 1 is based.
- R10: The operation output is the lower opcode nibble, and the qualifier output is byte 1.
- R11: The address of an operand that the class does not have is output as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_stb | input | 1 | Instruction bytes are presented this cycle |
| ins_bytes | input | 48 | Instruction byte k sits at bits [8k+7:8k]; byte 0 is the opcode |
| ix1 | input | 16 | Index register 1 |
| ix2 | input | 16 | Index register 2 |
| dec_vld | output | 1 | Decode results valid (one cycle after the strobe) |
| dec_cls | output | 2 | 00 command, 01 one operand, 10 two operands |
| dec_op | output | 4 | Lower opcode nibble |
| dec_q | output | 8 | Qualifier byte |
| dec_len | output | 3 | Instruction length in bytes |
| dec_ea1 | output | 16 | Effective address of operand 1 |
| dec_ea2 | output | 16 | Effective address of operand 2 |

## Verification
Every decoded result is due exactly one clock after the strobe: there is a single register stage and no combinational path to the outputs. The bench drives inputs on the falling edge. It updates its behavioural model of the expected registers at that same moment, and compares every output on the next falling edge, that is, half a period after the capturing edge. Idle cycles between strobes are compared too. On those cycles the expected valid flag is 0 and the expected fields are the values held from the last strobe.

// File: rtl/instr_format_decoder.sv
module instr_format_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ins_stb,
  input  logic [47:0] ins_bytes,
  input  logic [15:0] ix1,
  input  logic [15:0] ix2,
  output logic        dec_vld,
  output logic [1:0]  dec_cls,
  output logic [3:0]  dec_op,
  output logic [7:0]  dec_q,
  output logic [2:0]  dec_len,
  output logic [15:0] dec_ea1,
  output logic [15:0] dec_ea2
);
  localparam logic [1:0] CLS_CMD = 2'b00;
  localparam logic [1:0] CLS_ONE = 2'b01;
  localparam logic [1:0] CLS_TWO = 2'b10;
  localparam logic [1:0] M_DIR   = 2'b00;

  wire [3:0] hi = ins_bytes[7:4];

  logic [1:0]  cls, m1, m2;
  logic [2:0]  len, w1;
  logic [15:0] ea1, ea2;

  function automatic logic [15:0] form_ea(input logic [1:0] mode, input logic [7:0] b0,
                                          input logic [7:0] b1, input logic [15:0] r1,
                                          input logic [15:0] r2);
    case (mode)
      2'b00:   form_ea = {b0, b1};
      2'b01:   form_ea = r1 + {8'h00, b0};
      2'b10:   form_ea = r2 + {8'h00, b0};
      default: form_ea = 16'h0000;
    endcase
  endfunction

  always_comb begin
    m1 = M_DIR;
    m2 = M_DIR;
    if (hi == 4'hF) begin
      cls = CLS_CMD;
    end else if (hi[3:2] == 2'b11) begin
      cls = CLS_ONE;
      m1  = hi[1:0];
    end else if (hi[1:0] == 2'b11) begin
      cls = CLS_ONE;
      m1  = hi[3:2];
    end else begin
      cls = CLS_TWO;
      m1  = hi[3:2];
      m2  = hi[1:0];
    end
  end

  assign w1 = (m1 == M_DIR) ? 3'd2 : 3'd1;

  always_comb begin
    ea1 = 16'h0000;
    ea2 = 16'h0000;
    len = 3'd3;
    case (cls)
      CLS_ONE: begin
        ea1 = form_ea(m1, ins_bytes[23:16], ins_bytes[31:24], ix1, ix2);
        len = 3'd2 + w1;
      end
      CLS_TWO: begin
        ea1 = form_ea(m1, ins_bytes[23:16], ins_bytes[31:24], ix1, ix2);
        if (m1 == M_DIR)
          ea2 = form_ea(m2, ins_bytes[39:32], ins_bytes[47:40], ix1, ix2);
        else
          ea2 = form_ea(m2, ins_bytes[31:24], ins_bytes[39:32], ix1, ix2);
        len = 3'd2 + w1 + ((m2 == M_DIR) ? 3'd2 : 3'd1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_vld <= 1'b0;
      dec_cls <= CLS_CMD;
      dec_op  <= '0;
      dec_q   <= '0;
      dec_len <= '0;
      dec_ea1 <= '0;
      dec_ea2 <= '0;
    end else begin
      dec_vld <= ins_stb;
      if (ins_stb) begin
        dec_cls <= cls;
        dec_op  <= ins_bytes[3:0];
        dec_q   <= ins_bytes[15:8];
        dec_len <= len;
        dec_ea1 <= ea1;
        dec_ea2 <= ea2;
      end
    end
  end
endmodule

module instr_format_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ins_stb,
  input logic [47:0] ins_bytes,
  input logic        dec_vld,
  input logic [1:0]  dec_cls,
  input logic [3:0]  dec_op,
  input logic [7:0]  dec_q,
  input logic [2:0]  dec_len,
  input logic [15:0] dec_ea1,
  input logic [15:0] dec_ea2
);
  p_vld_after_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_stb |=> dec_vld);
  p_no_vld_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_stb |=> !dec_vld);
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_stb |=> ($stable(dec_cls) && $stable(dec_len) && $stable(dec_ea1) && $stable(dec_ea2)));
  p_cmd_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_stb && ins_bytes[7:4] == 4'hF) |=> (dec_cls == 2'b00 && dec_len == 3'd3));
  p_one_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_stb && ins_bytes[7:4] != 4'hF && (ins_bytes[7:6] == 2'b11 || ins_bytes[5:4] == 2'b11))
    |=> dec_cls == 2'b01);
  p_len_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> (dec_len >= 3'd3 && dec_len <= 3'd6 && dec_cls != 2'b11));
  p_op_q_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ins_stb |=> (dec_op == $past(ins_bytes[3:0]) && dec_q == $past(ins_bytes[15:8])));
  p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && dec_cls != 2'b10) |-> (dec_ea2 == 16'h0000));
endmodule

bind instr_format_decoder instr_format_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ins_stb(ins_stb), .ins_bytes(ins_bytes),
  .dec_vld(dec_vld), .dec_cls(dec_cls), .dec_op(dec_op), .dec_q(dec_q),
  .dec_len(dec_len), .dec_ea1(dec_ea1), .dec_ea2(dec_ea2));

// File: tb/instr_format_decoder_tb.sv
module instr_format_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_stb = 1'b0;
  logic [47:0] ins_bytes = '0;
  logic [15:0] ix1 = '0, ix2 = '0;
  logic        dec_vld;
  logic [1:0]  dec_cls;
  logic [3:0]  dec_op;
  logic [7:0]  dec_q;
  logic [2:0]  dec_len;
  logic [15:0] dec_ea1, dec_ea2;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  int e_vld = 0, e_cls = 0, e_op = 0, e_q = 0, e_len = 0, e_ea1 = 0, e_ea2 = 0;
  string t_cls = "R1", t_len = "R1", t_ea1 = "R1", t_ea2 = "R1", t_op = "R1";

  always #2 clk = ~clk;

  instr_format_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .ins_stb(ins_stb), .ins_bytes(ins_bytes),
    .ix1(ix1), .ix2(ix2), .dec_vld(dec_vld), .dec_cls(dec_cls), .dec_op(dec_op),
    .dec_q(dec_q), .dec_len(dec_len), .dec_ea1(dec_ea1), .dec_ea2(dec_ea2));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    chk("R2", "vld", dec_vld, e_vld);
    chk(t_cls, "cls", dec_cls, e_cls);
    chk(t_op, "op", dec_op, e_op);
    chk(t_op, "q", dec_q, e_q);
    chk(t_len, "len", dec_len, e_len);
    chk(t_ea1, "ea1", dec_ea1, e_ea1);
    chk(t_ea2, "ea2", dec_ea2, e_ea2);
  endtask

  function automatic int byte_of(input logic [47:0] v, input int k);
    return int'(v[8*k +: 8]);
  endfunction

  function automatic int operand(input int mode, input int pos, input logic [47:0] v,
                                 input int r1, input int r2, output int used);
    if (mode == 0) begin
      used = 2;
      return byte_of(v, pos) * 256 + byte_of(v, pos + 1);
    end
    used = 1;
    if (mode == 1) return (r1 + byte_of(v, pos)) % 65536;
    return (r2 + byte_of(v, pos)) % 65536;
  endfunction

  // Behavioural model: updates the expected register image for one strobe.
  task automatic model(input logic [47:0] v, input int r1, input int r2);
    int u, md1, md2, u1, u2, p2;
    u = byte_of(v, 0) / 16;
    e_op = byte_of(v, 0) % 16;
    e_q = byte_of(v, 1);
    t_op = "R10";
    e_ea1 = 0;
    e_ea2 = 0;
    t_ea2 = "R11";
    if (u == 15) begin
      e_cls = 0; e_len = 3; t_cls = "R3"; t_len = "R3"; t_ea1 = "R11";
    end else if (u / 4 == 3 || u % 4 == 3) begin
      md1 = (u / 4 == 3) ? u % 4 : u / 4;
      e_cls = 1; t_cls = "R4";
      e_ea1 = operand(md1, 2, v, r1, r2, u1);
      t_ea1 = (md1 == 0) ? "R7" : "R8";
      e_len = 2 + u1; t_len = "R6";
    end else begin
      md1 = u / 4; md2 = u % 4;
      e_cls = 2; t_cls = "R5";
      e_ea1 = operand(md1, 2, v, r1, r2, u1);
      t_ea1 = (md1 == 0) ? "R7" : "R8";
      p2 = 2 + u1;
      e_ea2 = operand(md2, p2, v, r1, r2, u2);
      t_ea2 = "R9";
      e_len = 2 + u1 + u2; t_len = "R6";
    end
  endtask

  task automatic step(input bit stb, input logic [47:0] v, input logic [15:0] r1, input logic [15:0] r2);
    @(negedge clk);
    compare_all();
    ins_stb = stb;
    ins_bytes = v;
    ix1 = r1;
    ix2 = r2;
    e_vld = stb;
    if (stb) model(v, int'(r1), int'(r2));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "vld in reset", dec_vld, 0);
    chk("R1", "len in reset", dec_len, 0);
    chk("R1", "ea1 in reset", dec_ea1, 0);
    rst_n = 1'b1;
    step(0, '0, 0, 0);
    step(0, '0, 0, 0);
    // R3 commands
    step(1, 48'h112233_4455_F2, 16'h1000, 16'h2000);
    step(1, 48'hFFFFFF_FFFF_FF, 16'hFFFF, 16'hFFFF);
    // R4 one-operand forms: 11xx and xx11 with every mode
    step(1, 48'h000000_3412_01C5, 16'h0100, 16'h0200);
    step(1, 48'h000000_0080_10D3, 16'h0100, 16'h0200);
    step(1, 48'h000000_00FF_20E7, 16'h0100, 16'h0200);
    step(1, 48'h000000_ABCD_3339, 16'h0100, 16'h0200);
    step(1, 48'h000000_0010_4478, 16'h0300, 16'h0400);
    step(1, 48'h000000_0011_55BA, 16'h0300, 16'h0400);
    // R8 wrap past 16 bits
    step(1, 48'h000000_0020_00D0, 16'hFFF0, 16'h0000);
    step(1, 48'h000000_00FF_00E0, 16'h0000, 16'hFF80);
    // R2 hold across idle cycles
    step(0, 48'hFFFFFF_FFFF_0F, 16'h1234, 16'h5678);
    step(0, '0, 0, 0);
    // R5 / R9 every two-operand mode pair
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        step(1, {8'h9A, 8'h78, 8'h56, 8'h34, 8'h12, 4'(a * 4 + b), 4'(a + b)},
             16'hF0F8, 16'h0F08);
    // back-to-back and random mix
    for (int i = 0; i < 3000; i++) begin
      logic [47:0] v;
      v = {$urandom, $urandom};
      step(($urandom % 4) != 0, v, 16'($urandom), 16'($urandom));
    end
    step(0, '0, 0, 0);
    step(0, '0, 0, 0);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule